// File: doc/BRIEF.md
# UART Transmit DMA Bridge

The bridge moves a programmed number of words from a memory read port into a four-entry staging FIFO, and from there into a UART transmit holding register, one byte at a time. Software supplies a start address, a word count, a word size and a completion mode, then pulses start. The memory side fetches words while the DMA enable is high and the FIFO has room. The peripheral side moves one word out of the FIFO for each transmit request.

A transmit request is edge-triggered. It fires when the holding-register-empty flag rises, or when the transmit enable rises while that flag is already high. The request stays pending until a FIFO entry is available. It is dropped whenever the block is idle or the transmit enable is low. Because of this, a transfer that begins while the holding register is still loaded continues on its own. A transfer that begins with the holding register already empty needs the transmit enable to be pulsed low and then high again.

Completion can be reported in one of two ways. In the first, the interrupt follows the memory side. In the second, it waits until the FIFO has drained. The run flag always covers the drain. The interrupt only means the last byte has been handed to the UART, not that the serial line has gone quiet. For that reason a separate idle output combines the run flag with the transmitter-empty flag.

Top module: `uart_tx_dma`

## Requirements
- R1: At most 4 words are held in the FIFO or in flight from memory at any time. With no transmit request, exactly 4 reads are issued and then fetching stops.
- R2: `mem_req_o` is only asserted while `dma_en_i` is high. A holding-register write only follows a cycle in which `tx_en_i` was high.
- R3: With `sync_i` = 0, `done_o` rises at the clock edge that writes the last word into the FIFO. This holds even if `tx_en_i` has never been set and no byte has been written out.
- R4: With `sync_i` = 1, `done_o` stays low while `run_o` is high, and rises at the same edge at which `run_o` falls.
- R5: `run_o` rises on an accepted start. It stays high after `done_o` sets, and falls at the edge that presents the final byte on the holding-register write port (the cycle after the final FIFO pop).
- R6: A transmit request is taken on a rising `thr_empty_i`, or on a rising `tx_en_i` while `thr_empty_i` is high. With `thr_empty_i` held high and `tx_en_i` held high, no byte is written until `tx_en_i` is pulsed low and then high.
- R7: A transfer started while `thr_empty_i` is low continues without any action on `tx_en_i` once `thr_empty_i` rises.
- R8: The `word_size_i` encoding is 2'b00 = 8-bit (address step 1) and 2'b01 = 16-bit (address step 2, low byte sent). A start with 2'b10, 2'b11 or a zero count sets `cfg_err_o` and is not run. Any later start clears `cfg_err_o`, and a valid one leaves it low.
- R9: `irq_o` follows `done_o`. `done_o` is cleared by a one-cycle `irq_ack_i` or by a new accepted start.
- R10: A start pulse while `run_o` is high is ignored. The current transfer's addresses and count are kept.
- R11: `tx_idle_o` is high only when `run_o` is low and `tsr_empty_i` is high.
- R12: Each popped word produces a one-cycle `thr_wr_o` with its low byte on `thr_data_o`. Bytes come out in memory-address order, starting at `start_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dma_en_i | input | 1 | Enables memory-side reads |
| start_i | input | 1 | Start pulse, sampled when idle |
| start_addr_i | input | AW | Byte address of the first word |
| word_cnt_i | input | CW | Number of words to move |
| word_size_i | input | 2 | 00 8-bit, 01 16-bit, others rejected |
| sync_i | input | 1 | 1: completion waits for FIFO drain |
| irq_ack_i | input | 1 | Write-one-to-clear of done |
| mem_req_o | output | 1 | One-cycle memory read request |
| mem_addr_o | output | AW | Read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | DW | Read data |
| tx_en_i | input | 1 | Transmit request enable |
| thr_empty_i | input | 1 | Holding register empty |
| tsr_empty_i | input | 1 | Transmitter fully empty |
| thr_wr_o | output | 1 | Holding-register write strobe |
| thr_data_o | output | 8 | Holding-register write data |
| done_o | output | 1 | Transfer complete flag |
| run_o | output | 1 | Transfer active, including FIFO drain |
| irq_o | output | 1 | Completion interrupt |
| cfg_err_o | output | 1 | Last start was rejected |
| tx_idle_o | output | 1 | Safe to stop the UART clock |

## Verification
The hardest state to reach from the ports is a transfer that begins with the holding register already empty and the transmit enable already high, since neither flag then produces an edge. The bench gets there by finishing a transfer, waiting until the transmitter stub reports fully empty, and then starting a one-word transfer with the enable left high. The chained case is the opposite. It is reached by issuing the next start in the cycle right after run falls, while the stub still holds the final byte of the previous transfer in its holding register behind a busy shifter.

// File: rtl/uart_tx_dma_pkg.sv
package uart_tx_dma_pkg;
  typedef enum logic [1:0] {
    WS_BYTE = 2'b00,
    WS_HALF = 2'b01,
    WS_WORD = 2'b10,
    WS_RSVD = 2'b11
  } wsize_e;

  function automatic logic size_ok(input logic [1:0] s);
    return (s == WS_BYTE) || (s == WS_HALF);
  endfunction
endpackage

// File: rtl/uart_tx_dma_fifo.sv
module uart_tx_dma_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic [LW-1:0] level_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [LW-1:0] lvl_q;
  logic          do_push, do_pop;

  assign empty_o = (lvl_q == '0);
  assign full_o  = (lvl_q == LW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rp_q];
  assign level_o = lvl_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          mem_q[g] <= '0;
      else if (do_push && wp_q == PW'(g))   mem_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      case ({do_push, do_pop})
        2'b10:   lvl_q <= lvl_q + LW'(1);
        2'b01:   lvl_q <= lvl_q - LW'(1);
        default: lvl_q <= lvl_q;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_dma_rd.sv
module uart_tx_dma_rd #(
  parameter int AW    = 32,
  parameter int CW    = 16,
  parameter int DEPTH = 4,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          half_i,
  input  logic          active_i,
  input  logic          dma_en_i,
  input  logic [LW-1:0] level_i,
  input  logic          rvalid_i,
  output logic          req_o,
  output logic [AW-1:0] addr_o,
  output logic          push_o,
  output logic          last_push_o,
  output logic          all_pushed_o,
  output logic          outst_o
);
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q, issued_q, pushed_q;
  logic          outst_q, half_q;

  // single outstanding read; FIFO room checked only when nothing is in flight
  assign req_o        = active_i && dma_en_i && !outst_q && (issued_q < cnt_q)
                        && (level_i < LW'(DEPTH));
  assign addr_o       = addr_q;
  assign push_o       = rvalid_i && outst_q;
  assign last_push_o  = push_o && (pushed_q == cnt_q - CW'(1));
  assign all_pushed_o = (pushed_q == cnt_q);
  assign outst_o      = outst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      cnt_q    <= '0;
      issued_q <= '0;
      pushed_q <= '0;
      outst_q  <= 1'b0;
      half_q   <= 1'b0;
    end else if (load_i) begin
      addr_q   <= base_i;
      cnt_q    <= cnt_i;
      issued_q <= '0;
      pushed_q <= '0;
      outst_q  <= 1'b0;
      half_q   <= half_i;
    end else begin
      if (req_o) begin
        addr_q   <= addr_q + (half_q ? AW'(2) : AW'(1));
        issued_q <= issued_q + CW'(1);
        outst_q  <= 1'b1;
      end else if (push_o) begin
        outst_q  <= 1'b0;
      end
      if (push_o) pushed_q <= pushed_q + CW'(1);
    end
  end
endmodule

// File: rtl/uart_tx_dma_req.sv
module uart_tx_dma_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tx_en_i,
  input  logic thr_empty_i,
  input  logic fifo_empty_i,
  output logic pop_o
);
  logic thr_q, en_q, pend_q, evt;

  assign evt   = (thr_empty_i && !thr_q) || (tx_en_i && !en_q && thr_empty_i);
  assign pop_o = pend_q && run_i && tx_en_i && !fifo_empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q  <= 1'b1;
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      thr_q <= thr_empty_i;
      en_q  <= tx_en_i;
      if (!run_i || !tx_en_i) pend_q <= 1'b0;
      else if (evt)           pend_q <= 1'b1;
      else if (pop_o)         pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_tx_dma.sv
module uart_tx_dma
  import uart_tx_dma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CW    = 16,
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dma_en_i,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [CW-1:0] word_cnt_i,
  input  logic [1:0]    word_size_i,
  input  logic          sync_i,
  input  logic          irq_ack_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          tx_en_i,
  input  logic          thr_empty_i,
  input  logic          tsr_empty_i,
  output logic          thr_wr_o,
  output logic [7:0]    thr_data_o,
  output logic          done_o,
  output logic          run_o,
  output logic          irq_o,
  output logic          cfg_err_o,
  output logic          tx_idle_o
);
  localparam int LW = $clog2(DEPTH + 1);

  logic          run_q, done_q, sync_q, err_q, wr_q;
  logic [7:0]    data_q;
  logic          start_seen, start_ok;
  logic          rd_push, rd_last, rd_all, rd_outst;
  logic          pop, final_pop, done_set;
  logic [7:0]    fifo_rdata;
  logic [LW-1:0] fifo_level;
  logic          fifo_empty, fifo_full;

  assign start_seen = start_i && !run_q;
  assign start_ok   = start_seen && size_ok(word_size_i) && (word_cnt_i != '0);

  uart_tx_dma_rd #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) u_rd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (start_ok),
    .base_i       (start_addr_i),
    .cnt_i        (word_cnt_i),
    .half_i       (word_size_i == WS_HALF),
    .active_i     (run_q),
    .dma_en_i     (dma_en_i),
    .level_i      (fifo_level),
    .rvalid_i     (mem_rvalid_i),
    .req_o        (mem_req_o),
    .addr_o       (mem_addr_o),
    .push_o       (rd_push),
    .last_push_o  (rd_last),
    .all_pushed_o (rd_all),
    .outst_o      (rd_outst)
  );

  // only the low byte ever reaches the UART, so only it is staged
  uart_tx_dma_fifo #(.W(8), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rd_push),
    .wdata_i (mem_rdata_i[7:0]),
    .pop_i   (pop),
    .rdata_o (fifo_rdata),
    .level_o (fifo_level),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  uart_tx_dma_req u_req (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run_q),
    .tx_en_i      (tx_en_i),
    .thr_empty_i  (thr_empty_i),
    .fifo_empty_i (fifo_empty),
    .pop_o        (pop)
  );

  assign final_pop = pop && (fifo_level == LW'(1)) && rd_all && !rd_push;
  assign done_set  = sync_q ? final_pop : rd_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      sync_q <= 1'b0;
      err_q  <= 1'b0;
      wr_q   <= 1'b0;
      data_q <= '0;
    end else begin
      wr_q <= pop;
      if (pop) data_q <= fifo_rdata;
      if (start_seen) err_q <= !start_ok;
      if (start_ok) begin
        run_q  <= 1'b1;
        sync_q <= sync_i;
      end else if (final_pop) begin
        run_q  <= 1'b0;
      end
      if (start_ok)       done_q <= 1'b0;
      else if (done_set)  done_q <= 1'b1;
      else if (irq_ack_i) done_q <= 1'b0;
    end
  end

  assign thr_wr_o   = wr_q;
  assign thr_data_o = data_q;
  assign done_o     = done_q;
  assign irq_o      = done_q;
  assign run_o      = run_q;
  assign cfg_err_o  = err_q;
  assign tx_idle_o  = !run_q && tsr_empty_i;
endmodule

// File: rtl/uart_tx_dma_chk.sv
module uart_tx_dma_chk #(
  parameter int DEPTH = 4,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          irq_ack_i,
  input logic          dma_en_i,
  input logic          tx_en_i,
  input logic          mem_req_o,
  input logic          thr_wr_o,
  input logic          run_o,
  input logic          done_o,
  input logic          sync_q,
  input logic          pop_i,
  input logic [LW-1:0] level_i,
  input logic          outst_i
);
  p_fifo_cap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(level_i) + int'(outst_i)) <= DEPTH);

  p_read_gated_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> dma_en_i);

  p_write_gated_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_wr_o |-> $past(tx_en_i));

  p_sync_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_q && run_o) |-> !done_o);

  p_sync_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_q && $fell(run_o)) |-> done_o);

  p_run_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_o) |-> $past(pop_i));

  p_done_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_o) |-> ($past(irq_ack_i) || $past(start_i)));

  p_start_only_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> $past(start_i));
endmodule

bind uart_tx_dma uart_tx_dma_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .irq_ack_i (irq_ack_i),
  .dma_en_i  (dma_en_i),
  .tx_en_i   (tx_en_i),
  .mem_req_o (mem_req_o),
  .thr_wr_o  (thr_wr_o),
  .run_o     (run_o),
  .done_o    (done_o),
  .sync_q    (sync_q),
  .pop_i     (pop),
  .level_i   (fifo_level),
  .outst_i   (rd_outst)
);

// File: tb/tb_uart_tx_dma.sv
`timescale 1ns/1ps
module tb_uart_tx_dma;
  localparam int AW = 32, CW = 16, DW = 16, DEPTH = 4;
  localparam int SHIFT = 20;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          dma_en = 1'b0, start = 1'b0, sync = 1'b0, ack = 1'b0, tx_en = 1'b0;
  logic [AW-1:0] base = '0;
  logic [CW-1:0] cnt = '0;
  logic [1:0]    wsize = 2'b00;
  logic          mem_req, mem_rvalid, thr_wr, done, run, irq, cfg_err, tx_idle;
  logic [AW-1:0] mem_addr, a1;
  logic [DW-1:0] mem_rdata;
  logic [7:0]    thr_data;
  logic          r1, thr_full, cur16 = 1'b0;
  int            tsr_cnt, wr_cnt, rd_cnt;
  logic [7:0]    log_q [256];
  int            n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  uart_tx_dma #(.AW(AW), .CW(CW), .DW(DW), .DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .dma_en_i(dma_en), .start_i(start),
    .start_addr_i(base), .word_cnt_i(cnt), .word_size_i(wsize), .sync_i(sync),
    .irq_ack_i(ack), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .tx_en_i(tx_en),
    .thr_empty_i(!thr_full), .tsr_empty_i(!thr_full && tsr_cnt == 0),
    .thr_wr_o(thr_wr), .thr_data_o(thr_data), .done_o(done), .run_o(run),
    .irq_o(irq), .cfg_err_o(cfg_err), .tx_idle_o(tx_idle)
  );

  function automatic logic [7:0] fb(input logic [AW-1:0] a);
    return 8'(a * 29 + 11);
  endfunction

  // memory model (latency 2) and UART holding/shift register stub
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1 <= 1'b0; a1 <= '0; mem_rvalid <= 1'b0; mem_rdata <= '0;
      thr_full <= 1'b0; tsr_cnt <= 0; wr_cnt <= 0; rd_cnt <= 0;
    end else begin
      r1 <= mem_req;
      a1 <= mem_addr;
      mem_rvalid <= r1;
      mem_rdata <= cur16 ? {fb(a1 + 1), fb(a1)} : {8'hA5, fb(a1)};
      if (mem_req) rd_cnt <= rd_cnt + 1;
      if (thr_wr) begin
        log_q[wr_cnt[7:0]] <= thr_data;
        wr_cnt <= wr_cnt + 1;
        thr_full <= 1'b1;
      end else if (thr_full && tsr_cnt == 0) begin
        thr_full <= 1'b0;
      end
      if (thr_full && tsr_cnt == 0 && !thr_wr) tsr_cnt <= SHIFT;
      else if (tsr_cnt != 0)                   tsr_cnt <= tsr_cnt - 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start(input logic [AW-1:0] b, input logic [CW-1:0] c,
                          input logic [1:0] s, input logic sy);
    @(negedge clk);
    base = b; cnt = c; wsize = s; sync = sy; start = 1'b1;
    cur16 = (s == 2'b01);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic pulse_en();
    @(negedge clk); tx_en = 1'b0;
    @(negedge clk); tx_en = 1'b1;
  endtask

  task automatic wait_run_low();
    for (int i = 0; i < 2000 && run; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && !tx_idle; i++) @(negedge clk);
  endtask

  task automatic chk_bytes(input int first, input logic [AW-1:0] b, input int step,
                           input int n, input string tag);
    for (int i = 0; i < n; i++)
      chk(log_q[8'(first + i)] == fb(b + AW'(i * step)), tag,
          log_q[8'(first + i)], fb(b + AW'(i * step)));
  endtask

  task automatic t_reset();
    chk(!run && !done && !irq, "R5 reset run/done", {run, done, irq}, 0);
    chk(!mem_req && !thr_wr && !cfg_err, "R8 reset req/wr/err", {mem_req, thr_wr, cfg_err}, 0);
    chk(tx_idle, "R11 reset idle", tx_idle, 1);
  endtask

  task automatic t_cfg();
    int r0 = rd_cnt;
    dma_en = 1'b1;
    do_start(32'h80, 16'd4, 2'b10, 1'b0);
    chk(cfg_err && !run, "R8 size 32 rejected", {cfg_err, run}, 2);
    do_start(32'h80, 16'd4, 2'b11, 1'b0);
    chk(cfg_err && !run, "R8 size 11 rejected", {cfg_err, run}, 2);
    do_start(32'h80, 16'd0, 2'b00, 1'b0);
    chk(cfg_err && !run, "R8 zero count rejected", {cfg_err, run}, 2);
    cyc(10);
    chk(rd_cnt == r0, "R8 no reads after reject", rd_cnt - r0, 0);
    dma_en = 1'b0;
  endtask

  task automatic t_async();
    int r0 = rd_cnt, w0 = wr_cnt;
    bit wr_seen;
    tx_en = 1'b0;
    do_start(32'h100, 16'd3, 2'b00, 1'b0);
    chk(!cfg_err, "R8 valid start clears error", cfg_err, 0);
    cyc(10);
    chk(run && rd_cnt == r0, "R2 no reads while dma disabled", rd_cnt - r0, 0);
    dma_en = 1'b1;
    for (int i = 0; i < 100 && !done; i++) @(negedge clk);
    chk(done && irq, "R3 done before tx enable", {done, irq}, 3);
    chk(rd_cnt - r0 == 3 && wr_cnt == w0, "R3 all read none written",
        (rd_cnt - r0) * 100 + (wr_cnt - w0), 300);
    chk(run, "R5 run held after done", run, 1);
    do_start(32'h500, 16'd5, 2'b01, 1'b1);
    cyc(10);
    chk(rd_cnt - r0 == 3, "R10 start ignored while running", rd_cnt - r0, 3);
    chk(wr_cnt == w0, "R2 no writes while tx disabled", wr_cnt - w0, 0);
    @(negedge clk); tx_en = 1'b1;
    wait_run_low();
    wr_seen = thr_wr;
    chk(!run && wr_seen, "R5 run falls with last write", {run, wr_seen}, 1);
    cyc(2);
    chk(wr_cnt - w0 == 3, "R12 byte count", wr_cnt - w0, 3);
    chk_bytes(w0, 32'h100, 1, 3, "R12 8-bit byte order");
    chk(done && irq, "R9 done held until ack", {done, irq}, 3);
    do_ack();
    chk(!done && !irq, "R9 ack clears done", {done, irq}, 0);
  endtask

  task automatic t_sync();
    int r0, w0;
    bit early;
    bit wr_seen;
    wait_idle();
    r0 = rd_cnt; w0 = wr_cnt;
    do_start(32'h200, 16'd10, 2'b01, 1'b1);
    cyc(30);
    chk(rd_cnt - r0 == 4, "R1 fetch stops at fifo depth", rd_cnt - r0, 4);
    chk(wr_cnt == w0 && run, "R6 no request without enable edge", wr_cnt - w0, 0);
    pulse_en();
    early = 1'b0;
    for (int i = 0; i < 2000 && run; i++) begin
      if (done) early = 1'b1;
      @(negedge clk);
    end
    wr_seen = thr_wr;
    chk(!early, "R4 done low during drain", early, 0);
    chk(done && !run && wr_seen, "R4 done with run fall", {done, run, wr_seen}, 5);
    chk(wr_cnt - w0 + 1 == 10, "R12 sync byte count", wr_cnt - w0 + 1, 10);
    cyc(1);
    chk_bytes(w0, 32'h200, 2, 10, "R8 16-bit low byte and step");
  endtask

  task automatic t_chain();
    int w0;
    bit thr_busy;
    thr_busy = thr_full;
    w0 = wr_cnt;
    do_ack();
    chk(thr_busy, "R7 holding register loaded at start", thr_busy, 1);
    do_start(32'h300, 16'd2, 2'b00, 1'b0);
    wait_run_low();
    cyc(1);
    chk(wr_cnt - w0 == 2, "R7 chained transfer runs on", wr_cnt - w0, 2);
    chk_bytes(w0, 32'h300, 1, 2, "R7 chained bytes");
    chk(!tx_idle, "R11 not idle while shifter busy", tx_idle, 0);
    wait_idle();
    chk(tx_idle && !run, "R11 idle after shifter empties", tx_idle, 1);
    do_ack();
  endtask

  task automatic t_repulse();
    int w0 = wr_cnt;
    do_start(32'h400, 16'd1, 2'b00, 1'b0);
    cyc(40);
    chk(wr_cnt == w0, "R6 empty holding register needs re-pulse", wr_cnt - w0, 0);
    chk(run && done, "R3 done while byte still queued", {run, done}, 3);
    pulse_en();
    wait_run_low();
    cyc(1);
    chk(wr_cnt - w0 == 1, "R6 re-pulse releases byte", wr_cnt - w0, 1);
    chk_bytes(w0, 32'h400, 1, 1, "R12 single byte");
    do_ack();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_cfg();
    t_async();
    t_sync();
    t_chain();
    t_repulse();
    cyc(5);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule